// File: doc/BRIEF.md
# 128-by-64 Divide-Remainder Unit

This block divides an unsigned 128-bit dividend by an unsigned 64-bit divisor. It returns a 64-bit quotient and a 64-bit remainder. The dividend is built from two 64-bit operands: a high half and a low half. The divisor is zero-extended to 128 bits before the divide. The datapath is a radix-2 restoring divider that retires one quotient bit per clock. A start/busy/done handshake sequences each operation.

The unit has two modes. In scalar mode the high half comes from the `opHi` port. In chain mode the high half comes from the remainder of the most recently completed operation, so a big integer can be divided by a one-digit scalar. Software feeds the digits most-significant first. The first digit of a chain takes zero as its high half. Two illegal requests are detected before any iteration starts: a zero divisor, and a quotient that would not fit in 64 bits. Either one completes at once with all-ones results and an error flag. Because the error result is all ones, a chain stops producing valid digits after its first error.

Top module: `divrem_wide`

## Requirements
- R1: With `chainMode`=0, the dividend is `opHi` in bits 127:64 and `opLo` in bits 63:0. On `done`, `quotient` is floor(dividend / `divisor`) and `remainder` is dividend mod `divisor`.
- R2: Every error-free result satisfies quotient*divisor + remainder = dividend, with remainder < divisor.
- R3: When `divisor` is nonzero and the selected high half is >= `divisor`, the request is an overflow. In that case `errOvf`=1, `errDivZero`=0, and `quotient` and `remainder` are both all ones. `done` pulses one cycle after the start and `busy` never rises.
- R4: When `divisor` is zero, `errDivZero`=1 and `errOvf`=0, whatever the high half is. `quotient` and `remainder` are both all ones, and `done` pulses one cycle after the start.
- R5: A start sampled while `busy`=0 with a legal request raises `busy` for exactly 64 cycles. `done` then pulses for one cycle as `busy` falls. The results and flags hold until the next accepted start.
- R6: With `chainMode`=1 and `chainFirst`=1, the high half is zero. With `chainMode`=1 and `chainFirst`=0, the high half is the `remainder` of the most recently completed operation. In chain mode `opHi` has no effect.
- R7: A chain head with a nonzero divisor never overflows. After an error, each later non-head chain element reports an error with all-ones results.
- R8: A `start` asserted while `busy`=1 is ignored. Neither the running result nor its completion cycle changes.
- R9: After reset, `busy`, `done`, `errOvf` and `errDivZero` are 0, and `quotient` and `remainder` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a divide; sampled only while idle |
| chainMode | input | 1 | 1 selects chain mode for the high half |
| chainFirst | input | 1 | In chain mode, marks the first (most significant) digit |
| opHi | input | 64 | High half of the dividend in scalar mode |
| opLo | input | 64 | Low half of the dividend |
| divisor | input | 64 | Divisor |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 64 | Quotient result |
| remainder | output | 64 | Remainder result |
| errOvf | output | 1 | Quotient would not fit in 64 bits |
| errDivZero | output | 1 | Divisor was zero |

## Verification
A corrupted partial remainder or a mis-shifted quotient bit shows up at the ports only when `done` pulses, 64 cycles after the start. The bench therefore checks every result in full and checks the division identity on each one. A wrong iteration count or a wrong state shows up sooner, in the first cycle where `busy` or `done` differs from the bench model, because the model is compared every cycle of every operation. A stale or mis-selected chain remainder shows up as a wrong quotient on the next chain digit.

// File: rtl/divrem_wide_pkg.sv
package divrem_wide_pkg;
  // Strobes sent from the sequencer to the datapath each cycle
  typedef struct packed {
    logic load;   // capture operands and begin iterating
    logic step;   // retire one quotient bit
    logic fault;  // reject the request with all-ones results
  } dpStrobe_t;

  typedef enum logic [0:0] {
    S_IDLE = 1'b0,
    S_RUN  = 1'b1
  } ctrlState_t;
endpackage

// File: rtl/divrem_step.sv
// One restoring iteration: shift in a dividend bit, subtract if it fits
module divrem_step #(
  parameter int DW = 64
) (
  input  logic [DW-1:0] remIn,
  input  logic          inBit,
  input  logic [DW-1:0] divisor,
  output logic [DW-1:0] remOut,
  output logic          qBit
);
  logic [DW:0] trial;
  logic [DW:0] diff;

  always_comb begin
    trial  = {remIn, inBit};
    diff   = trial - {1'b0, divisor};
    qBit   = (trial >= {1'b0, divisor});
    remOut = qBit ? diff[DW-1:0] : trial[DW-1:0];
  end
endmodule

// File: rtl/divrem_ctrl.sv
module divrem_ctrl
  import divrem_wide_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      preDivZero,
  input  logic      preOvf,
  output dpStrobe_t strobe,
  output logic      busy,
  output logic      done
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST_ITER = CW'(DW - 1);

  ctrlState_t state;
  logic [CW-1:0] iterCnt;
  logic reject;

  assign reject = preDivZero | preOvf;

  always_comb begin
    strobe = '0;
    if (state == S_IDLE && start) begin
      strobe.fault = reject;
      strobe.load  = !reject;
    end
    if (state == S_RUN) strobe.step = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      iterCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (start) begin
            if (reject) begin
              done <= 1'b1;
            end else begin
              state   <= S_RUN;
              iterCnt <= '0;
            end
          end
        end
        S_RUN: begin
          iterCnt <= iterCnt + 1'b1;
          if (iterCnt == LAST_ITER) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy = (state == S_RUN);
endmodule

// File: rtl/divrem_datapath.sv
module divrem_datapath
  import divrem_wide_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     strobe,
  input  logic          chainMode,
  input  logic          chainFirst,
  input  logic [DW-1:0] opHi,
  input  logic [DW-1:0] opLo,
  input  logic [DW-1:0] divisor,
  output logic          preDivZero,
  output logic          preOvf,
  output logic [DW-1:0] quotient,
  output logic [DW-1:0] remainder,
  output logic          errOvf,
  output logic          errDivZero
);
  logic [DW-1:0] remReg;
  logic [DW-1:0] quoReg;
  logic [DW-1:0] divReg;
  logic [DW-1:0] hiSel;
  logic [DW-1:0] remNext;
  logic          qBit;

  // High half: scalar operand, zero for a chain head, or the held remainder
  always_comb begin
    if (!chainMode)      hiSel = opHi;
    else if (chainFirst) hiSel = '0;
    else                 hiSel = remReg;
  end

  assign preDivZero = (divisor == '0);
  assign preOvf     = !preDivZero && (hiSel >= divisor);

  divrem_step #(.DW(DW)) step_i (
    .remIn   (remReg),
    .inBit   (quoReg[DW-1]),
    .divisor (divReg),
    .remOut  (remNext),
    .qBit    (qBit)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remReg     <= '0;
      quoReg     <= '0;
      divReg     <= '0;
      errOvf     <= 1'b0;
      errDivZero <= 1'b0;
    end else if (strobe.fault) begin
      remReg     <= '1;
      quoReg     <= '1;
      errOvf     <= preOvf;
      errDivZero <= preDivZero;
    end else if (strobe.load) begin
      remReg     <= hiSel;
      quoReg     <= opLo;
      divReg     <= divisor;
      errOvf     <= 1'b0;
      errDivZero <= 1'b0;
    end else if (strobe.step) begin
      remReg <= remNext;
      quoReg <= {quoReg[DW-2:0], qBit};
    end
  end

  assign quotient  = quoReg;
  assign remainder = remReg;
endmodule

// File: rtl/divrem_wide.sv
module divrem_wide
  import divrem_wide_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          chainMode,
  input  logic          chainFirst,
  input  logic [DW-1:0] opHi,
  input  logic [DW-1:0] opLo,
  input  logic [DW-1:0] divisor,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] quotient,
  output logic [DW-1:0] remainder,
  output logic          errOvf,
  output logic          errDivZero
);
  dpStrobe_t strobe;
  logic preDivZero;
  logic preOvf;

  divrem_ctrl #(.DW(DW)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .preDivZero (preDivZero),
    .preOvf     (preOvf),
    .strobe     (strobe),
    .busy       (busy),
    .done       (done)
  );

  divrem_datapath #(.DW(DW)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .chainMode  (chainMode),
    .chainFirst (chainFirst),
    .opHi       (opHi),
    .opLo       (opLo),
    .divisor    (divisor),
    .preDivZero (preDivZero),
    .preOvf     (preOvf),
    .quotient   (quotient),
    .remainder  (remainder),
    .errOvf     (errOvf),
    .errDivZero (errDivZero)
  );
endmodule

// File: rtl/divrem_wide_chk.sv
module divrem_wide_chk #(
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rstN,
  input logic          start,
  input logic          chainMode,
  input logic          chainFirst,
  input logic [DW-1:0] divisor,
  input logic          busy,
  input logic          done,
  input logic [DW-1:0] quotient,
  input logic [DW-1:0] remainder,
  input logic          errOvf,
  input logic          errDivZero
);
  // R5: completion is a single pulse and never overlaps iteration
  a_r5_busy_done_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r5_busy_from_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));
  // R3 / R4: a rejected request reports all ones
  a_r3_fault_all_ones: assert property (@(posedge clk) disable iff (!rstN)
    (done && (errOvf || errDivZero)) |-> (quotient == '1 && remainder == '1));
  a_r4_one_error_kind: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({errOvf, errDivZero}));
  // R7: a chain head with a nonzero divisor cannot overflow
  a_r7_chain_head_no_ovf: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && chainMode && chainFirst && divisor != '0) |=> !errOvf);
  // R8: a start during iteration does not restart the counter
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> (busy || done));
endmodule

bind divrem_wide divrem_wide_chk #(.DW(DW)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .start      (start),
  .chainMode  (chainMode),
  .chainFirst (chainFirst),
  .divisor    (divisor),
  .busy       (busy),
  .done       (done),
  .quotient   (quotient),
  .remainder  (remainder),
  .errOvf     (errOvf),
  .errDivZero (errDivZero)
);

// File: tb/divrem_wide_tb_top.sv
module divrem_wide_tb_top;
  localparam int DW = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic chainMode = 1'b0;
  logic chainFirst = 1'b0;
  logic [DW-1:0] opHi = '0;
  logic [DW-1:0] opLo = '0;
  logic [DW-1:0] divisor = '0;
  logic busy, done, errOvf, errDivZero;
  logic [DW-1:0] quotient, remainder;

  int testsRun = 0;
  int testsFailed = 0;
  logic finished = 1'b0;
  logic [DW-1:0] modelRem = '0;

  always #4 clk = ~clk;  // 125 MHz

  divrem_wide #(.DW(DW)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .chainMode(chainMode),
    .chainFirst(chainFirst), .opHi(opHi), .opLo(opLo), .divisor(divisor),
    .busy(busy), .done(done), .quotient(quotient), .remainder(remainder),
    .errOvf(errOvf), .errDivZero(errDivZero)
  );

  task automatic check(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Runs one request and compares the handshake on every cycle.
  // intAt > 0: a stray start with junk operands is raised after that many cycles.
  task automatic runOp(input logic [DW-1:0] hi, input logic [DW-1:0] lo,
                       input logic [DW-1:0] b, input logic cm, input logic cf,
                       input int intAt, input string req);
    logic [DW-1:0] effHi, expQ, expR;
    logic [127:0] dvd, qFull;
    logic expDz, expOv, err, timingOk;
    int lastE;
    effHi = cm ? (cf ? '0 : modelRem) : hi;
    expDz = (b == '0);
    expOv = !expDz && (effHi >= b);
    err   = expDz || expOv;
    dvd   = {effHi, lo};
    if (err) begin
      expQ = '1; expR = '1;
    end else begin
      qFull = dvd / {64'd0, b};
      expQ  = qFull[DW-1:0];
      qFull = dvd % {64'd0, b};
      expR  = qFull[DW-1:0];
    end
    lastE = err ? 0 : DW;
    timingOk = 1'b1;
    @(negedge clk);
    opHi = hi; opLo = lo; divisor = b; chainMode = cm; chainFirst = cf;
    start = 1'b1;
    for (int e = 0; e <= lastE; e++) begin
      @(negedge clk);
      if (e == 0) start = 1'b0;
      if (busy !== (!err && e < DW) || done !== (e == lastE)) begin
        if (timingOk)
          $display("FAIL R5 %s cycle %0d busy=%b done=%b", req, e, busy, done);
        timingOk = 1'b0;
      end
      if (intAt > 0 && e == intAt + 1) start = 1'b0;
      if (intAt > 0 && e == intAt) begin
        start = 1'b1; opLo = ~lo; opHi = '0; divisor = 64'd3;
      end
    end
    testsRun++;
    if (!timingOk) testsFailed++;
    check(quotient == expQ, {"R1 quotient ", req}, 128'(quotient), 128'(expQ));
    check(remainder == expR, {"R1 remainder ", req}, 128'(remainder), 128'(expR));
    check(errOvf == expOv && errDivZero == expDz, {"R3/R4 flags ", req},
          128'({errOvf, errDivZero}), 128'({expOv, expDz}));
    if (!err)
      check(({64'd0, quotient} * {64'd0, b} + {64'd0, remainder}) == dvd
            && remainder < b, {"R2 identity ", req},
            {64'd0, quotient} * {64'd0, b} + {64'd0, remainder}, dvd);
    // R5: pulse drops and the result holds
    @(negedge clk);
    check(!done && !busy && quotient == expQ && remainder == expR,
          {"R5 hold ", req}, {done, busy, quotient}, {2'b00, expQ});
    modelRem = expR;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check(!busy && !done && !errOvf && !errDivZero && quotient == '0
          && remainder == '0, "R9 reset",
          {busy, done, errOvf, errDivZero, quotient}, 128'd0);
    rstN = 1'b1;
    // R1 scalar cases
    runOp(64'd0, 64'd100, 64'd7, 1'b0, 1'b0, 0, "R1 small");
    runOp(64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210,
          64'hFFFF_FFFF_FFFF_FFF1, 1'b0, 1'b0, 0, "R1 large");
    runOp(64'hFFFF_FFFF_FFFF_FFF0, 64'hFFFF_FFFF_FFFF_FFFF,
          64'hFFFF_FFFF_FFFF_FFF1, 1'b0, 1'b0, 0, "R1 max quotient");
    runOp(64'd0, 64'hDEAD_BEEF_0000_0001, 64'd1, 1'b0, 1'b0, 0, "R1 unit divisor");
    // R3 overflow: high equal to and above divisor
    runOp(64'd9, 64'd5, 64'd9, 1'b0, 1'b0, 0, "R3 hi equal");
    runOp(64'hFFFF_0000_0000_0000, 64'd5, 64'd17, 1'b0, 1'b0, 0, "R3 hi above");
    // R4 divide by zero, with zero and nonzero high half
    runOp(64'd0, 64'd77, 64'd0, 1'b0, 1'b0, 0, "R4 zero hi");
    runOp(64'd5, 64'd77, 64'd0, 1'b0, 1'b0, 0, "R4 nonzero hi");
    // R8: start while busy ignored
    runOp(64'd3, 64'h1111_2222_3333_4444, 64'd1000, 1'b0, 1'b0, 10, "R8 restart");
    // R6 / R7: chain with opHi held at junk, most significant digit first
    runOp(64'hFFFF_FFFF_FFFF_FFFF, 64'hAAAA_5555_AAAA_5555, 64'd10,
          1'b1, 1'b1, 0, "R6 R7 chain head");
    runOp(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0007, 64'd10,
          1'b1, 1'b0, 0, "R6 chain digit 1");
    runOp(64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 64'd10,
          1'b1, 1'b0, 0, "R6 chain digit 2");
    // R7: error stops the chain
    runOp(64'd0, 64'd1, 64'd0, 1'b1, 1'b0, 0, "R7 chain zero divisor");
    runOp(64'd0, 64'd1, 64'd5, 1'b1, 1'b0, 0, "R7 chain halted");
    runOp(64'd0, 64'd1, 64'd5, 1'b1, 1'b1, 0, "R7 chain restart");
    // R2: varied scalar operands
    for (int i = 0; i < 40; i++) begin
      logic [DW-1:0] b, hi, lo;
      b  = {$urandom, $urandom} | 64'd1;
      if (i % 3 == 0) b = b >> (i % 60);
      if (b == '0) b = 64'd1;
      hi = {$urandom, $urandom} % b;
      lo = {$urandom, $urandom};
      runOp(hi, lo, b, 1'b0, 1'b0, 0, "R2 varied");
    end
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule